// File: doc/BRIEF.md
# Idle-Timed Serial Message Delimiter

This block sits behind a byte-wide asynchronous serial receiver. It cuts the incoming character stream into messages using nothing but the silence on the line. The protocol it serves carries no length field and no delimiter byte. A message therefore begins only after a long quiet period and ends only when another long quiet period follows it. A silence of medium length inside a message makes that message invalid. The block measures silence by counting bit-time ticks since the last received character. One character lasts eleven ticks. The short limit defaults to 17 ticks (just over 1.5 characters) and the long limit to 39 ticks (just over 3.5 characters).

Accepted bytes leave on a valid-only stream. `frm_start` flags the first byte of each message. A message finishes in one of two ways: `frm_end` with the byte count on `frm_len`, or `frm_abort`. After an abort, and after reset, the block ignores every character until the line has stayed quiet for the full long limit. The output stream has no ready signal, because a serial line cannot be paused. The sink must take every beat in the cycle in which `frm_valid` is high, and the block never stalls or buffers.

Top module: `rtu_gap_framer`

## Requirements
- R1: After reset, no character produces output until TICKS_LONG (39) bit ticks have passed with no character. Each character that arrives restarts this count.
- R2: A character that arrives on a line that has been quiet long enough raises `frm_start` and `frm_valid` together, one clock after `rx_valid`, with `frm_data` equal to the character.
- R3: Characters with zero idle ticks between them are all accepted and delivered in arrival order, each on `frm_valid` one clock after its `rx_valid`.
- R4: Inside a message, a character that arrives after TICKS_SHORT (17) or more idle ticks, and before TICKS_LONG, causes a one-clock `frm_abort` one clock later. That character is not delivered.
- R5: After an abort, characters are dropped and start no message until TICKS_LONG quiet ticks follow the last of them. The next character after that starts a message normally.
- R6: `frm_end` pulses once, one clock after the bit tick that brings the idle count after the last byte to TICKS_LONG. At that moment `frm_len` holds the number of bytes delivered. No `frm_end` appears after only TICKS_LONG-1 ticks.
- R7: Gaps of up to TICKS_SHORT-1 (16) idle ticks between characters keep the message intact.
- R8: An aborted message never produces `frm_end`.
- R9: A message may hold at most MAX_LEN (256) bytes. A further character aborts the message and is not delivered.
- R10: If `rx_valid` and `bit_tick` are high in the same clock, the character wins. That tick is not counted as idle time.
- R11: `frm_start`, `frm_end` and `frm_abort` are single-clock pulses, and no two of them are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-clock pulse per serial bit time |
| rx_valid | input | 1 | A character has been received this clock |
| rx_data | input | 8 | Received character |
| frm_start | output | 1 | First byte of a message is on the stream |
| frm_valid | output | 1 | Byte beat of the current message |
| frm_data | output | 8 | Byte value of the beat |
| frm_end | output | 1 | Message closed by long silence |
| frm_abort | output | 1 | Message discarded |
| frm_len | output | 9 | Byte count of the message, valid with frm_end |

## Verification
The checker watches several relations on every clock. The three pulses must be mutually exclusive. A start must coincide with a byte. Every delivered byte must mirror the previous clock's input character. An abort must follow a character, and an end must follow a tick without a character. An end or a middle-of-message byte is allowed only while a message is open. The reported length must stay in range. The exact tick counts cannot be checked this way, because they depend on the stimulus history rather than on neighbouring cycles. These are the 16-versus-17 short boundary, the 38-versus-39 end boundary, the dead zone after an abort and after reset, the 257th byte, and the case of a tick and a character in the same clock. Only the directed scenarios can show them.

// File: rtl/rtu_gap_pkg.sv
package rtu_gap_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_READY = 2'd1,
    ST_RECV  = 2'd2
  } fr_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/rtu_idle_timer.sv
module rtu_idle_timer #(
  parameter int unsigned T_SHORT = 17,
  parameter int unsigned T_LONG  = 39
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic gap_short,
  output logic long_hit
);
  localparam int unsigned CW = $clog2(T_LONG + 1);
  localparam logic [CW-1:0] LIM_S = CW'(T_SHORT);
  localparam logic [CW-1:0] LIM_L = CW'(T_LONG);
  localparam logic [CW-1:0] LIM_P = CW'(T_LONG - 1);

  logic [CW-1:0] cnt_q;

  // counts idle ticks since the last character, saturating at the long limit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LIM_L)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gap_short = (cnt_q >= LIM_S);
  assign long_hit  = tick && !restart && (cnt_q == LIM_P);
endmodule

// File: rtl/rtu_len_counter.sv
module rtu_len_counter #(
  parameter int unsigned MAX_LEN = 256
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           first,
  input  logic                           bump,
  output logic [$clog2(MAX_LEN+1)-1:0]   len,
  output logic                           full
);
  localparam int unsigned LW = $clog2(MAX_LEN + 1);
  localparam logic [LW-1:0] LEN_MAX = LW'(MAX_LEN);

  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (first) begin
      len_q <= LW'(1);
    end else if (bump) begin
      len_q <= len_q + 1'b1;
    end
  end

  assign len  = len_q;
  assign full = (len_q == LEN_MAX);
endmodule

// File: rtl/rtu_frame_fsm.sv
module rtu_frame_fsm
  import rtu_gap_pkg::*;
#(
  parameter int unsigned LW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              gap_short,
  input  logic              long_hit,
  input  logic [LW-1:0]     len,
  input  logic              len_full,
  output logic              len_first,
  output logic              len_bump,
  output logic              frm_start,
  output logic              frm_valid,
  output logic [BYTE_W-1:0] frm_data,
  output logic              frm_end,
  output logic              frm_abort,
  output logic [LW-1:0]     frm_len
);
  fr_state_e   st_q, st_d;
  logic        start_d, valid_d, end_d, abort_d;
  logic        start_q, valid_q, end_q, abort_q;
  logic [BYTE_W-1:0] data_q;
  logic [LW-1:0]     flen_q;

  always_comb begin
    st_d      = st_q;
    start_d   = 1'b0;
    valid_d   = 1'b0;
    end_d     = 1'b0;
    abort_d   = 1'b0;
    len_first = 1'b0;
    len_bump  = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        // dead zone: characters are dropped, only a full long silence re-arms
        if (!rx_valid && long_hit) st_d = ST_READY;
      end
      ST_READY: begin
        if (rx_valid) begin
          start_d   = 1'b1;
          valid_d   = 1'b1;
          len_first = 1'b1;
          st_d      = ST_RECV;
        end
      end
      ST_RECV: begin
        if (rx_valid) begin
          if (gap_short || len_full) begin
            abort_d = 1'b1;
            st_d    = ST_HUNT;
          end else begin
            valid_d  = 1'b1;
            len_bump = 1'b1;
          end
        end else if (long_hit) begin
          end_d = 1'b1;
          st_d  = ST_READY;
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_HUNT;
      start_q <= 1'b0;
      valid_q <= 1'b0;
      end_q   <= 1'b0;
      abort_q <= 1'b0;
      data_q  <= '0;
      flen_q  <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      valid_q <= valid_d;
      end_q   <= end_d;
      abort_q <= abort_d;
      if (valid_d) data_q <= rx_data;
      if (end_d)   flen_q <= len;
    end
  end

  assign frm_start = start_q;
  assign frm_valid = valid_q;
  assign frm_data  = data_q;
  assign frm_end   = end_q;
  assign frm_abort = abort_q;
  assign frm_len   = flen_q;
endmodule

// File: rtl/rtu_gap_framer.sv
module rtu_gap_framer #(
  parameter int unsigned TICKS_SHORT = 17,
  parameter int unsigned TICKS_LONG  = 39,
  parameter int unsigned MAX_LEN     = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_tick,
  input  logic                          rx_valid,
  input  logic [7:0]                    rx_data,
  output logic                          frm_start,
  output logic                          frm_valid,
  output logic [7:0]                    frm_data,
  output logic                          frm_end,
  output logic                          frm_abort,
  output logic [$clog2(MAX_LEN+1)-1:0]  frm_len
);
  localparam int unsigned LW = $clog2(MAX_LEN + 1);

  logic          gap_short, long_hit;
  logic          len_first, len_bump, len_full;
  logic [LW-1:0] len_cnt;

  rtu_idle_timer #(.T_SHORT(TICKS_SHORT), .T_LONG(TICKS_LONG)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (rx_valid),
    .tick      (bit_tick),
    .gap_short (gap_short),
    .long_hit  (long_hit)
  );

  rtu_len_counter #(.MAX_LEN(MAX_LEN)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .first (len_first),
    .bump  (len_bump),
    .len   (len_cnt),
    .full  (len_full)
  );

  rtu_frame_fsm #(.LW(LW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .gap_short (gap_short),
    .long_hit  (long_hit),
    .len       (len_cnt),
    .len_full  (len_full),
    .len_first (len_first),
    .len_bump  (len_bump),
    .frm_start (frm_start),
    .frm_valid (frm_valid),
    .frm_data  (frm_data),
    .frm_end   (frm_end),
    .frm_abort (frm_abort),
    .frm_len   (frm_len)
  );
endmodule

// File: rtl/rtu_gap_framer_chk.sv
module rtu_gap_framer_chk #(
  parameter int unsigned MAX_LEN = 256
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bit_tick,
  input logic                          rx_valid,
  input logic [7:0]                    rx_data,
  input logic                          frm_start,
  input logic                          frm_valid,
  input logic [7:0]                    frm_data,
  input logic                          frm_end,
  input logic                          frm_abort,
  input logic [$clog2(MAX_LEN+1)-1:0]  frm_len
);
  localparam int unsigned LW = $clog2(MAX_LEN + 1);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  open_q <= 1'b0;
    else if (frm_start)          open_q <= 1'b1;
    else if (frm_end || frm_abort) open_q <= 1'b0;
  end

  AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm_start, frm_end, frm_abort})); // R11
  AST_START_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> frm_valid); // R2
  AST_BYTE_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> ($past(rx_valid) && frm_data == $past(rx_data))); // R3
  AST_ABORT_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    frm_abort |-> $past(rx_valid)); // R4
  AST_END_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |-> ($past(bit_tick) && !$past(rx_valid))); // R10
  AST_END_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |-> open_q); // R8
  AST_BYTE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_start) |-> open_q); // R5
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |-> (frm_len != '0 && frm_len <= LW'(MAX_LEN))); // R9
endmodule

bind rtu_gap_framer rtu_gap_framer_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .rx_valid  (rx_valid),
  .rx_data   (rx_data),
  .frm_start (frm_start),
  .frm_valid (frm_valid),
  .frm_data  (frm_data),
  .frm_end   (frm_end),
  .frm_abort (frm_abort),
  .frm_len   (frm_len)
);

// File: tb/sim_rtu_gap_framer.sv
`timescale 1ns/1ps
module sim_rtu_gap_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       frm_start, frm_valid, frm_end, frm_abort;
  logic [7:0] frm_data;
  logic [8:0] frm_len;

  always #2.5 clk = ~clk;

  rtu_gap_framer u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_valid(rx_valid),
    .rx_data(rx_data), .frm_start(frm_start), .frm_valid(frm_valid),
    .frm_data(frm_data), .frm_end(frm_end), .frm_abort(frm_abort),
    .frm_len(frm_len)
  );

  int n_checks = 0, n_fail = 0;
  int n_start = 0, n_valid = 0, n_end = 0, n_abort = 0, last_len = 0;
  int excl_bad = 0, start_nobyte = 0;
  logic [7:0] got [0:511];
  bit clr_req = 1'b0;

  // event logger, sampled on the falling edge
  always @(negedge clk) begin
    if (clr_req) begin
      n_start = 0; n_valid = 0; n_end = 0; n_abort = 0; last_len = 0;
      clr_req = 1'b0;
    end
    if (rst_n) begin
      if (frm_start) n_start++;
      if (frm_valid) begin
        if (n_valid < 512) got[n_valid] = frm_data;
        n_valid++;
      end
      if (frm_end) begin n_end++; last_len = int'(frm_len); end
      if (frm_abort) n_abort++;
      if ((32'(frm_start) + 32'(frm_end) + 32'(frm_abort)) > 1) excl_bad++;
      if (frm_start && !frm_valid) start_nobyte++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic t);
    @(posedge clk); #1;
    rx_valid = v; rx_data = d; bit_tick = t;
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b0);
  endtask

  task automatic clear_log();
    settle();
    clr_req = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b0);
  endtask

  task automatic send(input logic [7:0] d);
    step(1'b1, d, 1'b0);
    step(1'b0, 8'h00, 1'b0);
  endtask

  task automatic t_reset_state();
    check(!frm_start && !frm_valid && !frm_end && !frm_abort, "R11 reset outputs",
          int'(frm_start | frm_valid | frm_end | frm_abort), 0);
  endtask

  task automatic t_hunt_after_reset();
    clear_log();
    ticks(30); send(8'h11); ticks(38); send(8'h22);
    settle();
    check(n_start == 0 && n_valid == 0, "R1 early chars dropped", n_valid, 0);
    ticks(39);
    send(8'h33); ticks(39); settle();
    check(n_start == 1 && n_valid == 1 && got[0] == 8'h33, "R1 start after quiet", n_valid, 1);
  endtask

  task automatic t_burst_frame();
    clear_log();
    step(1'b1, 8'hA1, 1'b0); step(1'b1, 8'hB2, 1'b0); step(1'b1, 8'hC3, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    settle();
    check(n_start == 1, "R2 start pulse", n_start, 1);
    check(n_valid == 3 && got[0] == 8'hA1 && got[1] == 8'hB2 && got[2] == 8'hC3,
          "R3 back-to-back bytes", n_valid, 3);
    ticks(38); settle();
    check(n_end == 0, "R6 no end at 38 ticks", n_end, 0);
    ticks(1); settle();
    check(n_end == 1 && last_len == 3, "R6 end and length", last_len, 3);
    ticks(45); settle();
    check(n_end == 1, "R6 end only once", n_end, 1);
  endtask

  task automatic t_gap_ok();
    clear_log();
    send(8'h01); ticks(16); send(8'h02); ticks(16); send(8'h03); ticks(39); settle();
    check(n_abort == 0 && n_valid == 3, "R7 16-tick gaps kept", n_valid, 3);
    check(n_end == 1 && last_len == 3, "R7 end length", last_len, 3);
  endtask

  task automatic t_abort();
    clear_log();
    send(8'h44); ticks(17); send(8'h55); settle();
    check(n_abort == 1 && n_valid == 1, "R4 abort on 17-tick gap", n_abort, 1);
    ticks(20); send(8'h66); ticks(38); send(8'h77); ticks(38); settle();
    check(n_start == 1 && n_valid == 1, "R5 dead zone drops chars", n_valid, 1);
    check(n_end == 0, "R8 no end after abort", n_end, 0);
    ticks(1); send(8'h88); ticks(39); settle();
    check(n_start == 2 && n_valid == 2 && got[1] == 8'h88, "R5 resync after quiet", n_valid, 2);
    check(n_end == 1 && last_len == 1, "R5 resync frame ends", last_len, 1);
  endtask

  task automatic t_overflow();
    clear_log();
    for (int i = 0; i < 257; i++) step(1'b1, 8'(i), 1'b0);
    step(1'b0, 8'h00, 1'b0);
    settle();
    check(n_valid == 256 && n_abort == 1, "R9 257th byte aborts", n_valid, 256);
    check(got[255] == 8'hFF, "R9 last delivered byte", int'(got[255]), 255);
    ticks(39); settle();
    check(n_end == 0, "R9 R8 no end after overflow", n_end, 0);
    send(8'h5A); ticks(39); settle();
    check(n_end == 1 && last_len == 1, "R9 recovery frame", last_len, 1);
  endtask

  task automatic t_same_cycle();
    clear_log();
    send(8'h10); ticks(16);
    step(1'b1, 8'h20, 1'b1); step(1'b0, 8'h00, 1'b0);
    ticks(39); settle();
    check(n_abort == 0 && n_valid == 2 && got[1] == 8'h20, "R10 char wins over tick", n_valid, 2);
    check(n_end == 1 && last_len == 2, "R10 end length", last_len, 2);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset_state();
    rst_n = 1'b1;
    t_hunt_after_reset();
    t_burst_frame();
    t_gap_ok();
    t_abort();
    t_overflow();
    t_same_cycle();
    check(excl_bad == 0, "R11 pulses exclusive", excl_bad, 0);
    check(start_nobyte == 0, "R2 start with byte", start_nobyte, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule